// File: doc/BRIEF.md
# Processor Exception Mode Controller

This block holds the operating mode and the two interrupt-mask bits of a 32-bit RISC core and moves the core between modes when the pipeline raises exception events. A reset request, a fast interrupt, a normal interrupt, a data abort, a prefetch abort, an undefined instruction or a supervisor call is sampled on each rising clock edge. When several of these arrive in the same cycle, one of them is chosen by a fixed priority. The chosen event moves the core into its handler mode, sets the proper mask bits and reports a vector index for one cycle.

Software can also rewrite the status byte through a write port. That write takes effect only from a privileged mode and only with a legal mode value. This write is the single route into system mode, which is privileged but is never the target of an exception. The block also drives a privileged flag and a register-bank select that the register file uses to choose its banked copies.

Top module: `mode_ctrl`

## Requirements
- R1: While rst_ni is low, status_o reads 8'hD3 (supervisor mode 10011 in bits 4:0, fast mask bit 6 set, normal mask bit 7 set, bit 5 zero), vec_valid_o is 0, priv_o is 1 and bank_o is 3.
- R2: rst_req_i wins over every other event. On the next edge the mode becomes supervisor, both mask bits are set and vector 0 is reported.
- R3: When events coincide, the one taken is the first of this list: reset request, data abort, fast interrupt, normal interrupt, prefetch abort, undefined instruction, supervisor call. A masked interrupt does not take part.
- R4: fiq_i is taken only while bit 6 is clear. It enters mode 10001, sets bits 6 and 7, and reports vector 7.
- R5: irq_i is taken only while bit 7 is clear. It enters mode 10010, sets bit 7, leaves bit 6 unchanged, and reports vector 6.
- R6: A data abort reports vector 4 and a prefetch abort reports vector 3. Both enter mode 10111, set bit 7 and leave bit 6 unchanged.
- R7: An undefined instruction enters mode 11011 and reports vector 1. A supervisor call enters mode 10011 and reports vector 2. Both set bit 7 and leave bit 6 unchanged.
- R8: A write (wr_en_i) from a privileged mode loads bits 4:0 into the mode, bit 6 into the fast mask and bit 7 into the normal mask on the next edge. System mode 11111 can be entered only this way.
- R9: A write made while in user mode 10000 leaves status_o unchanged.
- R10: A write is ignored if its mode value is not one of 10000, 10001, 10010, 10011, 10111, 11011 or 11111, or if its bit 5 is set.
- R11: An exception taken in the same cycle as a write wins, and the write is discarded.
- R12: priv_o is 0 only in user mode. bank_o is 0 for user and system, 1 for fast interrupt, 2 for normal interrupt, 3 for supervisor, 4 for abort and 5 for undefined.
- R13: vec_valid_o is high for exactly the one cycle after an exception is taken, with vec_o holding its vector. It is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rst_req_i | input | 1 | Synchronous reset event |
| fiq_i | input | 1 | Fast interrupt request |
| irq_i | input | 1 | Normal interrupt request |
| swi_i | input | 1 | Supervisor-call instruction |
| pabt_i | input | 1 | Prefetch abort |
| dabt_i | input | 1 | Data abort |
| undef_i | input | 1 | Undefined instruction |
| wr_en_i | input | 1 | Status write strobe |
| wr_data_i | input | 8 | Status write value |
| status_o | output | 8 | Status byte: mode, fast mask, normal mask |
| mode_o | output | 5 | Current mode |
| priv_o | output | 1 | Privileged flag |
| vec_valid_o | output | 1 | Exception taken in the previous cycle |
| vec_o | output | 3 | Vector index of the last exception |
| bank_o | output | 3 | Register-bank select |

## Verification
Some rules are checked by assertions on every cycle. The reset request always wins. A masked fast interrupt is never taken. No exception lands in system mode. The mode always holds a legal encoding. A user-mode write never changes the status, and the user bank is chosen whenever the core is unprivileged. The full priority ladder needs the bench's scenarios, which set up a status value and then fire combinations of events. The same holds for the exact mask-bit side effects of each entry, the rejection of illegal writes, and a write colliding with an exception.

// File: rtl/mc_pkg.sv
package mc_pkg;
  localparam int MODE_W = 5;
  localparam int STAT_W = 8;
  localparam int VEC_W  = 3;
  localparam int BANK_W = 3;
  localparam int N_EV   = 7;
  localparam int IDX_W  = $clog2(N_EV);
  localparam int F_BIT  = 6;
  localparam int I_BIT  = 7;
  localparam int R_BIT  = 5;

  localparam logic [MODE_W-1:0] M_USR = 5'b10000;
  localparam logic [MODE_W-1:0] M_FIQ = 5'b10001;
  localparam logic [MODE_W-1:0] M_IRQ = 5'b10010;
  localparam logic [MODE_W-1:0] M_SVC = 5'b10011;
  localparam logic [MODE_W-1:0] M_ABT = 5'b10111;
  localparam logic [MODE_W-1:0] M_UND = 5'b11011;
  localparam logic [MODE_W-1:0] M_SYS = 5'b11111;

  // event index = priority rank, 0 highest
  localparam int EX_RST  = 0;
  localparam int EX_DABT = 1;
  localparam int EX_FIQ  = 2;
  localparam int EX_IRQ  = 3;
  localparam int EX_PABT = 4;
  localparam int EX_UND  = 5;
  localparam int EX_SWI  = 6;

  function automatic logic mode_legal(input logic [MODE_W-1:0] m);
    case (m)
      M_USR, M_FIQ, M_IRQ, M_SVC, M_ABT, M_UND, M_SYS: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [MODE_W-1:0] mode_of(input logic [IDX_W-1:0] x);
    case (int'(x))
      EX_RST, EX_SWI:   return M_SVC;
      EX_DABT, EX_PABT: return M_ABT;
      EX_FIQ:           return M_FIQ;
      EX_IRQ:           return M_IRQ;
      default:          return M_UND;
    endcase
  endfunction

  function automatic logic [VEC_W-1:0] vec_of(input logic [IDX_W-1:0] x);
    case (int'(x))
      EX_RST:  return 3'd0;
      EX_UND:  return 3'd1;
      EX_SWI:  return 3'd2;
      EX_PABT: return 3'd3;
      EX_DABT: return 3'd4;
      EX_IRQ:  return 3'd6;
      default: return 3'd7;
    endcase
  endfunction
endpackage

// File: rtl/mc_arbiter.sv
module mc_arbiter
  import mc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_EV-1:0]  req_i,
  input  logic             fdis_i,
  input  logic             idis_i,
  output logic             take_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [N_EV-1:0] eff;

  always_comb begin
    eff = req_i;
    eff[EX_FIQ] = req_i[EX_FIQ] & ~fdis_i;
    eff[EX_IRQ] = req_i[EX_IRQ] & ~idis_i;
  end

  // scan low to high priority, last hit wins
  always_comb begin
    take_o = 1'b0;
    idx_o  = '0;
    for (int k = N_EV - 1; k >= 0; k--) begin
      if (eff[k]) begin
        take_o = 1'b1;
        idx_o  = IDX_W'(k);
      end
    end
  end

  AST_RST_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i[EX_RST] |-> (take_o && idx_o == IDX_W'(EX_RST))); // R2
  AST_FIQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && idx_o == IDX_W'(EX_FIQ)) |-> !fdis_i); // R4
  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && idx_o == IDX_W'(EX_IRQ)) |-> !idis_i); // R5
endmodule

// File: rtl/mc_status.sv
module mc_status
  import mc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              wr_en_i,
  input  logic [STAT_W-1:0] wr_data_i,
  output logic [MODE_W-1:0] mode_o,
  output logic              fdis_o,
  output logic              idis_o,
  output logic              vv_o,
  output logic [VEC_W-1:0]  vec_o
);
  logic [MODE_W-1:0] mode_q, mode_n;
  logic              f_q, f_n, i_q, i_n, vv_q, vv_n;
  logic [VEC_W-1:0]  vec_q, vec_n;
  logic              wr_ok;

  assign wr_ok = wr_en_i && (mode_q != M_USR) && !wr_data_i[R_BIT]
                 && mode_legal(wr_data_i[MODE_W-1:0]);

  always_comb begin
    mode_n = mode_q;
    f_n    = f_q;
    i_n    = i_q;
    vv_n   = 1'b0;
    vec_n  = vec_q;
    if (take_i) begin
      mode_n = mode_of(idx_i);
      i_n    = 1'b1;
      if (idx_i == IDX_W'(EX_RST) || idx_i == IDX_W'(EX_FIQ)) f_n = 1'b1;
      vv_n   = 1'b1;
      vec_n  = vec_of(idx_i);
    end else if (wr_ok) begin
      mode_n = wr_data_i[MODE_W-1:0];
      f_n    = wr_data_i[F_BIT];
      i_n    = wr_data_i[I_BIT];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= M_SVC;
      f_q    <= 1'b1;
      i_q    <= 1'b1;
      vv_q   <= 1'b0;
      vec_q  <= '0;
    end else begin
      mode_q <= mode_n;
      f_q    <= f_n;
      i_q    <= i_n;
      vv_q   <= vv_n;
      vec_q  <= vec_n;
    end
  end

  assign mode_o = mode_q;
  assign fdis_o = f_q;
  assign idis_o = i_q;
  assign vv_o   = vv_q;
  assign vec_o  = vec_q;

  AST_LEGAL_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_legal(mode_q)); // R10
  AST_NO_SYS_BY_EXC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |=> (mode_q != M_SYS)); // R8
  AST_FIQ_SETS_BOTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && idx_i == IDX_W'(EX_FIQ)) |=> (f_q && i_q && mode_q == M_FIQ)); // R4
  AST_EXC_MASKS_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |=> (i_q && vv_q)); // R13
  AST_USER_WR_IGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!take_i && mode_q == M_USR) |=> ($stable(mode_q) && $stable(f_q) && $stable(i_q))); // R9
endmodule

// File: rtl/mc_bank_map.sv
module mc_bank_map
  import mc_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  output logic              priv_o,
  output logic [BANK_W-1:0] bank_o
);
  always_comb begin
    priv_o = 1'b1;
    case (mode_i)
      M_USR:   begin bank_o = BANK_W'(0); priv_o = 1'b0; end
      M_FIQ:   bank_o = BANK_W'(1);
      M_IRQ:   bank_o = BANK_W'(2);
      M_SVC:   bank_o = BANK_W'(3);
      M_ABT:   bank_o = BANK_W'(4);
      M_UND:   bank_o = BANK_W'(5);
      default: bank_o = BANK_W'(0);
    endcase
  end
endmodule

// File: rtl/mode_ctrl.sv
module mode_ctrl
  import mc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rst_req_i,
  input  logic              fiq_i,
  input  logic              irq_i,
  input  logic              swi_i,
  input  logic              pabt_i,
  input  logic              dabt_i,
  input  logic              undef_i,
  input  logic              wr_en_i,
  input  logic [STAT_W-1:0] wr_data_i,
  output logic [STAT_W-1:0] status_o,
  output logic [MODE_W-1:0] mode_o,
  output logic              priv_o,
  output logic              vec_valid_o,
  output logic [VEC_W-1:0]  vec_o,
  output logic [BANK_W-1:0] bank_o
);
  logic [N_EV-1:0]  req;
  logic             take, fdis, idis;
  logic [IDX_W-1:0] idx;

  always_comb begin
    req          = '0;
    req[EX_RST]  = rst_req_i;
    req[EX_DABT] = dabt_i;
    req[EX_FIQ]  = fiq_i;
    req[EX_IRQ]  = irq_i;
    req[EX_PABT] = pabt_i;
    req[EX_UND]  = undef_i;
    req[EX_SWI]  = swi_i;
  end

  mc_arbiter u_arb (
    .clk_i (clk_i), .rst_ni (rst_ni), .req_i (req),
    .fdis_i(fdis), .idis_i (idis), .take_o (take), .idx_o (idx)
  );

  mc_status u_stat (
    .clk_i  (clk_i), .rst_ni (rst_ni), .take_i (take), .idx_i (idx),
    .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .mode_o (mode_o),
    .fdis_o (fdis), .idis_o (idis), .vv_o (vec_valid_o), .vec_o (vec_o)
  );

  mc_bank_map u_bank (.mode_i(mode_o), .priv_o(priv_o), .bank_o(bank_o));

  always_comb begin
    status_o = '0;
    status_o[MODE_W-1:0] = mode_o;
    status_o[F_BIT] = fdis;
    status_o[I_BIT] = idis;
  end

  AST_USER_BANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !priv_o |-> (bank_o == '0 && mode_o == M_USR)); // R12
endmodule

// File: tb/sim_mode_ctrl.sv
module sim_mode_ctrl;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rst_req = 0, fiq = 0, irq = 0, swi = 0, pabt = 0, dabt = 0, und = 0;
  logic       wr_en = 0;
  logic [7:0] wr_data = '0;
  logic [7:0] status;
  logic [4:0] mode;
  logic       priv, vv;
  logic [2:0] vec, bank;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  mode_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_ni), .rst_req_i(rst_req), .fiq_i(fiq), .irq_i(irq),
    .swi_i(swi), .pabt_i(pabt), .dabt_i(dabt), .undef_i(und), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .status_o(status), .mode_o(mode), .priv_o(priv),
    .vec_valid_o(vv), .vec_o(vec), .bank_o(bank)
  );

  // {init_status, events{rst,dabt,fiq,irq,pabt,und,swi}, exp_status, exp_vv, exp_vec}
  localparam int NV = 17;
  localparam logic [26:0] TBL [NV] = '{
    {8'h10, 7'b0010000, 8'hD1, 1'b1, 3'd7},  // R4
    {8'h10, 7'b0001000, 8'h92, 1'b1, 3'd6},  // R5
    {8'h10, 7'b0100000, 8'h97, 1'b1, 3'd4},  // R6
    {8'h10, 7'b0000100, 8'h97, 1'b1, 3'd3},  // R6
    {8'h10, 7'b0000010, 8'h9B, 1'b1, 3'd1},  // R7
    {8'h10, 7'b0000001, 8'h93, 1'b1, 3'd2},  // R7
    {8'h50, 7'b0010000, 8'h50, 1'b0, 3'd0},  // R4 masked
    {8'h90, 7'b0001000, 8'h90, 1'b0, 3'd0},  // R5 masked
    {8'h10, 7'b0011000, 8'hD1, 1'b1, 3'd7},  // R3
    {8'h10, 7'b0110000, 8'h97, 1'b1, 3'd4},  // R3
    {8'h10, 7'b1110000, 8'hD3, 1'b1, 3'd0},  // R2
    {8'h10, 7'b0001100, 8'h92, 1'b1, 3'd6},  // R3
    {8'h10, 7'b0000110, 8'h97, 1'b1, 3'd3},  // R3
    {8'h10, 7'b0000011, 8'h9B, 1'b1, 3'd1},  // R3
    {8'h90, 7'b0001100, 8'h97, 1'b1, 3'd3},  // R3 masked irq skipped
    {8'h50, 7'b0011000, 8'hD2, 1'b1, 3'd6},  // R3 masked fiq skipped
    {8'h1F, 7'b0000001, 8'h93, 1'b1, 3'd2}   // R7 from system
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic fire(input logic [6:0] e);
    {rst_req, dabt, fiq, irq, pabt, und, swi} = e;
    @(negedge clk);
    {rst_req, dabt, fiq, irq, pabt, und, swi} = '0;
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic setup(input logic [7:0] d);
    fire(7'b1000000);
    wr(d);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 status", 32'(status), 32'hD3);
    chk("R1 vv", 32'(vv), 0);
    chk("R1 priv", 32'(priv), 1);
    chk("R1 bank", 32'(bank), 3);
    rst_ni = 1'b1;
    @(negedge clk);

    for (int n = 0; n < NV; n++) begin
      setup(TBL[n][26:19]);
      fire(TBL[n][18:12]);
      chk($sformatf("R3 row%0d status", n), 32'(status), 32'(TBL[n][11:4]));
      chk($sformatf("R13 row%0d vv", n), 32'(vv), 32'(TBL[n][3]));
      if (TBL[n][3]) chk($sformatf("R13 row%0d vec", n), 32'(vec), 32'(TBL[n][2:0]));
    end

    // R8 privileged write into system mode
    setup(8'h1F);
    chk("R8 sys status", 32'(status), 32'h1F);
    chk("R12 sys priv", 32'(priv), 1);
    chk("R12 sys bank", 32'(bank), 0);
    wr(8'h30);
    chk("R10 reserved bit5 write", 32'(status), 32'h1F);
    wr(8'h10);
    chk("R8 to user", 32'(status), 32'h10);
    chk("R12 user priv", 32'(priv), 0);
    chk("R12 user bank", 32'(bank), 0);
    // R9 user writes ignored
    wr(8'h1F);
    chk("R9 user write sys", 32'(status), 32'h10);
    wr(8'hD3);
    chk("R9 user write svc", 32'(status), 32'h10);
    // R10 illegal modes ignored
    setup(8'h13);
    wr(8'h14);
    chk("R10 illegal 10100", 32'(status), 32'h13);
    wr(8'hC5);
    chk("R10 illegal 00101", 32'(status), 32'h13);
    // R11 exception beats write
    wr_en = 1'b1; wr_data = 8'h1F; irq = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; irq = 1'b0;
    chk("R11 status", 32'(status), 32'h92);
    chk("R11 vec", 32'(vec), 6);
    chk("R12 irq bank", 32'(bank), 2);
    @(negedge clk);
    chk("R13 vv drops", 32'(vv), 0);
    // R12 fiq bank, abort bank, undefined bank
    setup(8'h10);
    fire(7'b0010000);
    chk("R12 fiq bank", 32'(bank), 1);
    setup(8'h10);
    fire(7'b0100000);
    chk("R12 abt bank", 32'(bank), 4);
    setup(8'h10);
    fire(7'b0000010);
    chk("R12 und bank", 32'(bank), 5);
    // R2 reset request from user
    setup(8'h10);
    fire(7'b1001111);
    chk("R2 status", 32'(status), 32'hD3);
    chk("R2 vec", 32'(vec), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule